// File: doc/BRIEF.md
# Board Control Register Bank

This block is a 32-bit memory-mapped bank of board control registers. It decodes only the low twenty address bits, so the bank repeats through the rest of the address space. A bus master writes in a single cycle and reads combinationally. The bank drives an eight-bit LED bar, an eight-character text buffer for a front-panel display, a break/reset byte and an eight-bit general-purpose output. Fixed identification words cover the switches, the jumpers and the byte order.

The text buffer takes either single characters or a whole 32-bit word. A word write is shown as eight uppercase hexadecimal digits. Writing one exact magic value to the soft-reset location produces a one-cycle system reset request. A two-wire serial port is bit-banged by software through four registers: output enable, output level, input and loopback select. Each write to the output register hands the clock bit and the data bit to an attached responder, and the responder returns its data line on an input pin.

Top module: `board_ctl_regs`

## Requirements
- R1: Only address bits [19:0] select a register, so any upper address bits alias. A read of an offset with no register returns 0, and a write to such an offset changes no output and no readable value.
- R2: Offsets 0x200 (switches) and 0x210 (jumpers) always read 0. Writes to them are ignored.
- R3: Offset 0x208 reads 0x12 when parameter BIG_ENDIAN is 1 and 0x10 when it is 0.
- R4: Offset 0x408 is the LED bar. It resets to 0, keeps only write data bits [7:0], drives `led_bar` and reads back zero-extended.
- R5: A write to 0x410 loads all eight display characters with the ASCII uppercase hex digits of the data word. The character at `disp_text[63:56]` shows data bits [31:28], and each following lower byte shows the next lower nibble. Digits 0-9 map to 0x30-0x39 and digits A-F to 0x41-0x46.
- R6: A write to 0x418 + 8*k, for k from 0 to 7, loads character k (`disp_text[63-8k -: 8]`) with write data bits [7:0].
- R7: A write of exactly 0x00000042 to 0x500 raises `sys_reset_pulse` for exactly the one cycle after the write edge. Any other value, or any other offset, leaves it low.
- R8: Offset 0x508 keeps 8 bits and resets to 0x0A (`brk_reg`). Offset 0xA00 keeps 8 bits and resets to 0 (`gp_out`). Both read back zero-extended.
- R9: Offset 0xB08 (output enable, `i2c_oe`) keeps bits [1:0] and resets to 0. Offset 0xB18 (select) keeps bit 0 and resets to 1. Both read back.
- R10: Offset 0xB10 stores the whole 32-bit word and resets to 3. `i2c_scl_o` is its bit 1 and `i2c_sda_o` is its bit 0. `i2c_update` is high for the one cycle after each write to it.
- R11: Offset 0xB00 reads 0x2 with bit 0 replaced by `i2c_sda_i`. Offset 0xA08 reads the 0xB10 register when select is 1, and 0 when select is 0.
- R12: After reset, all eight display characters are ASCII space (0x20).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Byte address; only bits [19:0] are decoded |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| led_bar | output | 8 | LED bar drive |
| disp_text | output | 64 | Eight display characters, character 0 in the top byte |
| sys_reset_pulse | output | 1 | One-cycle system reset request |
| brk_reg | output | 8 | Break/reset register value |
| gp_out | output | 8 | General-purpose output |
| i2c_oe | output | 2 | Serial port output enables |
| i2c_scl_o | output | 1 | Clock level passed to the responder |
| i2c_sda_o | output | 1 | Data level passed to the responder |
| i2c_update | output | 1 | One-cycle strobe: new levels valid for the responder |
| i2c_sda_i | input | 1 | Data line returned by the responder |

## Verification
The bench builds the bank with BIG_ENDIAN set to 1, so the status word must read 0x12. The 32-bit data and address widths are kept, and these give exactly eight display characters and the full alias range in the upper address bits. With these values every hex digit, every character slot, the magic-value comparison over all 32 bits and the aliased addresses above bit 19 can be reached. The responder input is toggled by the bench, so both values of bit 0 at 0xB00 are observed.

// File: rtl/bcr_pkg.sv
`timescale 1ns/1ps
// Shared offsets, write-select type and hex digit helper for the board
// control register bank. Offsets are byte offsets in the decoded window.
package bcr_pkg;
    localparam logic [19:0] OFF_SWITCH  = 20'h00200;
    localparam logic [19:0] OFF_STATUS  = 20'h00208;
    localparam logic [19:0] OFF_JUMPER  = 20'h00210;
    localparam logic [19:0] OFF_LED     = 20'h00408;
    localparam logic [19:0] OFF_WORD    = 20'h00410;
    localparam logic [19:0] OFF_CHAR0   = 20'h00418;
    localparam int          CHAR_STRIDE = 8;
    localparam logic [19:0] OFF_SOFTRST = 20'h00500;
    localparam logic [19:0] OFF_BRK     = 20'h00508;
    localparam logic [19:0] OFF_GPO     = 20'h00A00;
    localparam logic [19:0] OFF_GPIN    = 20'h00A08;
    localparam logic [19:0] OFF_I2C_IN  = 20'h00B00;
    localparam logic [19:0] OFF_I2C_OE  = 20'h00B08;
    localparam logic [19:0] OFF_I2C_OUT = 20'h00B10;
    localparam logic [19:0] OFF_I2C_SEL = 20'h00B18;

    // One write-enable bit per writable scalar register.
    typedef struct packed {
        logic led;
        logic word;
        logic softrst;
        logic brk;
        logic gpo;
        logic i2c_oe;
        logic i2c_out;
        logic i2c_sel;
    } wsel_t;

    // ASCII uppercase hexadecimal digit for a nibble.
    function automatic logic [7:0] hex_char(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
    endfunction
endpackage

// File: rtl/bcr_decode.sv
`timescale 1ns/1ps
// Write decoder. Turns the decoded offset and the write strobe into one
// enable per scalar register and one enable per display character.
// Assumes an exact offset match: misaligned offsets select nothing.
module bcr_decode
    import bcr_pkg::*;
#(
    parameter int OFF_W = 20,
    parameter int NCH   = 8
) (
    input  logic [OFF_W-1:0] off,
    input  logic             we,
    output wsel_t            wsel,
    output logic [NCH-1:0]   ch_we
);
    // Scalar register write enables.
    always_comb begin
        wsel = '0;
        if (we) begin
            case (off)
                OFF_W'(OFF_LED):     wsel.led     = 1'b1;
                OFF_W'(OFF_WORD):    wsel.word    = 1'b1;
                OFF_W'(OFF_SOFTRST): wsel.softrst = 1'b1;
                OFF_W'(OFF_BRK):     wsel.brk     = 1'b1;
                OFF_W'(OFF_GPO):     wsel.gpo     = 1'b1;
                OFF_W'(OFF_I2C_OE):  wsel.i2c_oe  = 1'b1;
                OFF_W'(OFF_I2C_OUT): wsel.i2c_out = 1'b1;
                OFF_W'(OFF_I2C_SEL): wsel.i2c_sel = 1'b1;
                default:             wsel         = '0;
            endcase
        end
    end

    // Per-character enables on a fixed stride from the first slot.
    for (genvar k = 0; k < NCH; k++) begin : g_ch
        assign ch_we[k] = we && (off == OFF_W'(32'(OFF_CHAR0) + k * CHAR_STRIDE));
    end
endmodule

// File: rtl/bcr_text_buf.sv
`timescale 1ns/1ps
// Display character buffer. A word write loads every character with the
// hex digit of its nibble (character 0 = most significant nibble); a
// character write loads one byte. Assumes DATA_W == 4*NCH and that the
// word and character enables are never high together.
module bcr_text_buf
    import bcr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NCH    = DATA_W / 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_we,
    input  logic [NCH-1:0]    ch_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [8*NCH-1:0]  text
);
    localparam int NIB = 4;
    localparam logic [7:0] BLANK = 8'h20;

    for (genvar k = 0; k < NCH; k++) begin : g_char
        logic [7:0] ch_q;

        // Hold one character: blank on reset, hex digit or raw byte on write.
        always_ff @(posedge clk) begin
            if (!rst_n)          ch_q <= BLANK;
            else if (word_we)    ch_q <= hex_char(wdata[DATA_W-1-NIB*k -: NIB]);
            else if (ch_we[k])   ch_q <= wdata[7:0];
        end

        assign text[8*(NCH-1-k) +: 8] = ch_q;

        a_r6_char_load: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(ch_we[k]) && !$past(word_we))
                |-> (text[8*(NCH-1-k) +: 8] == $past(wdata[7:0])));
    end
endmodule

// File: rtl/bcr_magic_pulse.sv
`timescale 1ns/1ps
// Soft-reset trigger. Registers a single-cycle pulse when the soft-reset
// location is written with exactly MAGIC over the full data width.
module bcr_magic_pulse #(
    parameter int               DATA_W = 32,
    parameter logic [DATA_W-1:0] MAGIC = DATA_W'(32'h42)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [DATA_W-1:0] wdata,
    output logic              pulse
);
    // Pulse for one cycle after a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= hit && (wdata == MAGIC);
    end

    a_r7_fires: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hit) && ($past(wdata) == MAGIC)) |-> pulse);
    a_r7_only_on_magic: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> ($past(hit) && ($past(wdata) == MAGIC)));
endmodule

// File: rtl/board_ctl_regs.sv
`timescale 1ns/1ps
// Board control register bank. Decodes the low OFF_W address bits and
// holds LED, break, general output, serial-port bit-bang registers and a
// display buffer. Reads are combinational; writes land on the clock edge.
// Assumes one bus access per cycle and synchronous active-low reset.
module board_ctl_regs
    import bcr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int OFF_W      = 20,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [7:0]        led_bar,
    output logic [2*DATA_W-1:0] disp_text,
    output logic              sys_reset_pulse,
    output logic [7:0]        brk_reg,
    output logic [7:0]        gp_out,
    output logic [1:0]        i2c_oe,
    output logic              i2c_scl_o,
    output logic              i2c_sda_o,
    output logic              i2c_update,
    input  logic              i2c_sda_i
);
    localparam int NCH = DATA_W / 4;
    localparam logic [DATA_W-1:0] STATUS_VAL  = BIG_ENDIAN ? DATA_W'(32'h12) : DATA_W'(32'h10);
    localparam logic [DATA_W-1:0] I2C_IN_RST  = DATA_W'(32'h3);
    localparam logic [DATA_W-1:0] I2C_OUT_RST = DATA_W'(32'h3);
    localparam logic [7:0]        BRK_RST     = 8'h0A;

    logic [OFF_W-1:0]  off;
    wsel_t             wsel;
    logic [NCH-1:0]    ch_we;
    logic              sel_q;
    logic [DATA_W-1:0] i2c_out_q;
    logic              unused_addr_hi;

    assign off            = bus_addr[OFF_W-1:0];
    assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFF_W];

    bcr_decode #(.OFF_W(OFF_W), .NCH(NCH)) u_dec (
        .off   (off),
        .we    (bus_we),
        .wsel  (wsel),
        .ch_we (ch_we)
    );

    bcr_text_buf #(.DATA_W(DATA_W), .NCH(NCH)) u_text (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_we (wsel.word),
        .ch_we   (ch_we),
        .wdata   (bus_wdata),
        .text    (disp_text)
    );

    bcr_magic_pulse #(.DATA_W(DATA_W)) u_soft (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (wsel.softrst),
        .wdata (bus_wdata),
        .pulse (sys_reset_pulse)
    );

    // Scalar registers: reset values and write masking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_bar    <= '0;
            brk_reg    <= BRK_RST;
            gp_out     <= '0;
            i2c_oe     <= '0;
            sel_q      <= 1'b1;
            i2c_out_q  <= I2C_OUT_RST;
            i2c_update <= 1'b0;
        end else begin
            if (wsel.led)     led_bar   <= bus_wdata[7:0];
            if (wsel.brk)     brk_reg   <= bus_wdata[7:0];
            if (wsel.gpo)     gp_out    <= bus_wdata[7:0];
            if (wsel.i2c_oe)  i2c_oe    <= bus_wdata[1:0];
            if (wsel.i2c_sel) sel_q     <= bus_wdata[0];
            if (wsel.i2c_out) i2c_out_q <= bus_wdata;
            i2c_update <= wsel.i2c_out;
        end
    end

    assign i2c_scl_o = i2c_out_q[1];
    assign i2c_sda_o = i2c_out_q[0];

    // Read multiplexer on the decoded offset.
    always_comb begin
        case (off)
            OFF_W'(OFF_SWITCH):  bus_rdata = '0;
            OFF_W'(OFF_STATUS):  bus_rdata = STATUS_VAL;
            OFF_W'(OFF_JUMPER):  bus_rdata = '0;
            OFF_W'(OFF_LED):     bus_rdata = DATA_W'(led_bar);
            OFF_W'(OFF_BRK):     bus_rdata = DATA_W'(brk_reg);
            OFF_W'(OFF_GPO):     bus_rdata = DATA_W'(gp_out);
            OFF_W'(OFF_GPIN):    bus_rdata = sel_q ? i2c_out_q : '0;
            OFF_W'(OFF_I2C_IN):  bus_rdata = {I2C_IN_RST[DATA_W-1:1], i2c_sda_i};
            OFF_W'(OFF_I2C_OE):  bus_rdata = DATA_W'(i2c_oe);
            OFF_W'(OFF_I2C_OUT): bus_rdata = i2c_out_q;
            OFF_W'(OFF_I2C_SEL): bus_rdata = DATA_W'(sel_q);
            default:             bus_rdata = '0;
        endcase
    end

    a_r4_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wsel.led)) |-> $stable(led_bar));
    a_r8_brk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wsel.brk)) |-> $stable(brk_reg));
    a_r10_update_levels: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wsel.i2c_out))
            |-> (i2c_update && ({i2c_scl_o, i2c_sda_o} == $past(bus_wdata[1:0]))));
endmodule

// File: tb/sim_board_ctl_regs.sv
`timescale 1ns/1ps
module sim_board_ctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic        sda_in = 1'b1;
    logic [31:0] rdata;
    logic [7:0]  led, brk, gpo;
    logic [63:0] text;
    logic        srst, scl, sda, upd;
    logic [1:0]  oe;

    board_ctl_regs #(.BIG_ENDIAN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .led_bar(led),
        .disp_text(text), .sys_reset_pulse(srst), .brk_reg(brk),
        .gp_out(gpo), .i2c_oe(oe), .i2c_scl_o(scl), .i2c_sda_o(sda),
        .i2c_update(upd), .i2c_sda_i(sda_in)
    );

    always #10 clk = ~clk;

    int checks = 0, failures = 0, cyc = 0;
    bit started = 0, done = 0;

    // Behavioural reference state.
    logic [7:0]  m_led, m_brk, m_gpo;
    logic [1:0]  m_oe;
    logic        m_sel, m_srst, m_upd;
    logic [31:0] m_i2c;
    byte         m_ch[8];

    function automatic logic [63:0] m_text();
        logic [63:0] t;
        for (int i = 0; i < 8; i++) t[63-8*i -: 8] = m_ch[i];
        return t;
    endfunction

    function automatic logic [31:0] m_read(input logic [31:0] a);
        case (a & 32'hFFFFF)
            32'h200, 32'h210: return 0;
            32'h208: return 32'h12;
            32'h408: return {24'h0, m_led};
            32'h508: return {24'h0, m_brk};
            32'hA00: return {24'h0, m_gpo};
            32'hA08: return m_sel ? m_i2c : 0;
            32'hB00: return {31'h1, sda_in};
            32'hB08: return {30'h0, m_oe};
            32'hB10: return m_i2c;
            32'hB18: return {31'h0, m_sel};
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input logic [31:0] a);
        case (a & 32'hFFFFF)
            32'h200, 32'h210: return "R2";
            32'h208: return "R3";
            32'h408: return "R4";
            32'h508, 32'hA00: return "R8";
            32'hB08, 32'hB18: return "R9";
            32'hB10: return "R10";
            32'hA08, 32'hB00: return "R11";
            default: return "R1";
        endcase
    endfunction

    // Reference model update on each clock edge.
    always @(posedge clk) begin
        started = 1;
        cyc++;
        m_srst = 0; m_upd = 0;
        if (!rst_n) begin
            m_led = 0; m_brk = 8'h0A; m_gpo = 0; m_oe = 0; m_sel = 1;
            m_i2c = 3;
            for (int i = 0; i < 8; i++) m_ch[i] = 8'h20;
        end else if (we) begin
            int o;
            o = int'(wdata & 0) + int'(addr & 32'hFFFFF);
            case (o)
                'h408: m_led = wdata[7:0];
                'h410: for (int i = 0; i < 8; i++) begin
                    int n;
                    n = int'((wdata >> (28 - 4*i)) & 15);
                    m_ch[i] = (n < 10) ? byte'(48 + n) : byte'(65 + n - 10);
                end
                'h500: m_srst = (wdata == 32'h42);
                'h508: m_brk = wdata[7:0];
                'hA00: m_gpo = wdata[7:0];
                'hB08: m_oe = wdata[1:0];
                'hB10: begin m_i2c = wdata; m_upd = 1; end
                'hB18: m_sel = wdata[0];
                default: if (o >= 'h418 && o <= 'h450 && (o % 8) == 0)
                    m_ch[(o - 'h418) / 8] = wdata[7:0];
            endcase
        end
        if (cyc > 20000 && !done) begin
            failures++;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected<20000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, got, exp, $time);
        end
    endtask

    // Compare every output against the model on every cycle.
    always @(negedge clk) if (started) begin
        chk(req_of(addr), {32'h0, rdata}, {32'h0, m_read(addr)});
        chk("R4",  {56'h0, led}, {56'h0, m_led});
        chk("R5/R6/R12", text, m_text());
        chk("R7",  {63'h0, srst}, {63'h0, m_srst});
        chk("R8",  {48'h0, brk, gpo}, {48'h0, m_brk, m_gpo});
        chk("R9",  {62'h0, oe}, {62'h0, m_oe});
        chk("R10", {61'h0, scl, sda, upd}, {61'h0, m_i2c[1], m_i2c[0], m_upd});
    end

    task automatic step(input logic [31:0] a, input logic [31:0] d, input logic w);
        @(negedge clk); #2;
        addr = a; wdata = d; we = w;
    endtask

    task automatic settle();
        step(32'h0, 32'h0, 1'b0);
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk); #1;
        // R12 / reset values, literal expectations
        chk("R12", text, "        ");
        chk("R4", {56'h0, led}, 64'h0);
        chk("R8", {56'h0, brk}, 64'h0A);
        chk("R10", {62'h0, scl, sda}, 64'h3);
        // reads of every register after reset
        foreach (u0.bus_rdata[i]) begin end
        step(32'h200, 0, 0); step(32'h208, 0, 0); step(32'h210, 0, 0);
        step(32'hB18, 0, 0); step(32'hA08, 0, 0); step(32'hB00, 0, 0);
        settle();
        // R3 literal
        addr = 32'h208; #1 chk("R3", {32'h0, rdata}, 64'h12);
        // R4 masking, R1 aliasing
        step(32'h408, 32'hFFFF_F1A5, 1); step(32'h408, 0, 0);
        step(32'hFFF0_0408, 32'h0000_003C, 1); step(32'h7A30_0408, 0, 0);
        settle(); chk("R1", {56'h0, led}, 64'h3C);
        // R2 writes ignored, R1 unmapped write/read
        step(32'h200, 32'hFFFF_FFFF, 1); step(32'h210, 32'hFFFF_FFFF, 1);
        step(32'h404, 32'hFFFF_FFFF, 1); step(32'h412, 32'hFFFF_FFFF, 1);
        step(32'h200, 0, 0); step(32'h404, 0, 0); step(32'h210, 0, 0);
        settle();
        // R5 word formatting
        step(32'h410, 32'h0123_ABCD, 1); settle();
        chk("R5", text, "0123ABCD");
        step(32'h410, 32'h89EF_4567, 1); settle();
        chk("R5", text, "89EF4567");
        // R6 per-character writes
        for (int k = 0; k < 8; k++) step(32'h418 + 8*k, 32'hFFFF_FF61 + k, 1);
        settle(); chk("R6", text, "abcdefgh");
        step(32'h430, 32'h0000_1258, 1); settle();
        chk("R6", text, "abcXefgh");
        // R7 magic value only
        step(32'h500, 32'h42, 1); settle();
        step(32'h500, 32'h43, 1); step(32'h500, 32'h142, 1);
        step(32'h508, 32'h42, 1); step(32'h500, 32'h42, 1);
        step(32'h500, 32'h42, 1); settle();
        // R8
        step(32'h508, 32'h1234_56F0, 1); step(32'hA00, 32'hABCD_EF99, 1);
        step(32'h508, 0, 0); step(32'hA00, 0, 0);
        // R9
        step(32'hB08, 32'hFFFF_FFFF, 1); step(32'hB08, 0, 0);
        step(32'hB18, 32'hFFFF_FFFE, 1); step(32'hB18, 0, 0);
        // R10 / R11
        step(32'hB10, 32'h1234_5672, 1); step(32'hB10, 0, 0);
        step(32'hA08, 0, 0);
        step(32'hB18, 32'h1, 1); step(32'hA08, 0, 0);
        step(32'hB10, 32'hDEAD_BEE1, 1); step(32'hB10, 32'hCAFE_0000, 1);
        step(32'hA08, 0, 0);
        step(32'hB00, 0, 0); #1 sda_in = 1'b0;
        step(32'hB00, 0, 0); #1 sda_in = 1'b1;
        step(32'hB00, 0, 0);
        settle();
        addr = 32'hB00; sda_in = 1'b0; #1 chk("R11", {32'h0, rdata}, 64'h2);
        sda_in = 1'b1; #1 chk("R11", {32'h0, rdata}, 64'h3);
        settle();
        // reset again returns everything to its reset value
        step(32'h0, 0, 0); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #2 rst_n = 1'b1;
        settle(); chk("R12", text, "        ");
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule